// File: doc/BRIEF.md
# Eight-Digit Decimal Event Counter with Snapshot Register

This block counts events in decimal. It has a chain of BCD digits, eight by default. Each falling edge on the count input adds one to the total. When the total passes the largest value it can hold, it returns to zero.

A separate active-low clear input zeroes every digit and a sticky overflow flag. An active-low load input copies the live digits into a bank of holding registers, which drive the display-side outputs. The same load input copies the overflow flag into a held overflow bit. While load stays low, the copy is refreshed on every clock. Once load returns high, the held value stays fixed while the live count keeps moving.

The weight-8 bit of each of the upper three digits is brought out live. Wiring one of these taps back to the overflow input sets the sticky flag when that digit rolls from 9 to 0.

All four control inputs are asynchronous to the system clock. Each one is resynchronized through a two-stage register chain, and falling edges are found by comparing against a delayed copy.

Top module: `dcnt_top`

## Requirements
- R1: Each falling edge of `cnt_in` raises the live total by exactly one. Rising edges and steady levels leave it unchanged.
- R2: Digits hold values 0 to 9 only. A digit at 9 that is incremented returns to 0 and carries one into the next higher digit. `disp_bcd[4*i+3:4*i]` holds digit i, and digit 0 is the least significant.
- R3: With every digit at 9, the next count edge returns every digit to 0.
- R4: While `clr_n` is low, all digits and the sticky overflow flag are held at zero, and count edges have no effect.
- R5: While `ld_n` is low, the held digits follow the live digits. While `ld_n` is high, the held digits keep their last value.
- R6: `ovf_out` is the held copy of the sticky overflow flag. It updates only while `ld_n` is low.
- R7: The sticky overflow flag sets on a falling edge of `ovf_in`. It stays set until a clear.
- R8: `tap_msb[k]` is bit 3 (weight 8) of live digit `NUM_DECADES-TAP_COUNT+k`. It is not taken from the held copy.
- R9: While `rst` is high at a clock edge, the live digits, held digits, overflow flag and `ovf_out` all become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_in | input | 1 | Count input; a falling edge adds one |
| clr_n | input | 1 | Active-low clear of the digits and the overflow flag |
| ld_n | input | 1 | Active-low load of the holding registers |
| ovf_in | input | 1 | Overflow input; a falling edge sets the sticky flag |
| disp_bcd | output | 4*NUM_DECADES | Held digits in BCD, digit 0 in the low nibble |
| ovf_out | output | 1 | Held overflow flag |
| tap_msb | output | TAP_COUNT | Live weight-8 bits of the upper digits |

## Verification
The assertions assume that every control input holds each level for at least two system clocks. Otherwise the synchronizer could miss a pulse, and the one-step increment rule would not cover that case.

The stimulus keeps every level for three clocks or more. After each change it waits several clocks before sampling, so the two synchronizer stages, the edge register and the digit register have all settled.

A three-digit copy of the block has its top tap looped back to its overflow input. This makes the wrap and overflow behaviour reachable within a short run.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

    localparam int DIGIT_W   = 4;
    localparam int SYNC_LEN  = 2;

    typedef logic [DIGIT_W-1:0] bcd_t;

    localparam bcd_t BCD_TOP  = 4'd9;
    localparam bcd_t BCD_ZERO = 4'd0;

    // decoded, synchronized control view of the asynchronous inputs
    typedef struct packed {
        logic clr;       // clear active (level)
        logic load;      // holding registers transparent (level)
        logic cnt_fall;  // one-cycle pulse per count falling edge
        logic ovf_fall;  // one-cycle pulse per overflow-input falling edge
    } ctl_t;

    function automatic bcd_t bcd_next(input bcd_t v);
        return (v >= BCD_TOP) ? BCD_ZERO : bcd_t'(v + 4'd1);
    endfunction

    function automatic logic bcd_last(input bcd_t v);
        return v == BCD_TOP;
    endfunction

endpackage

// File: rtl/dcnt_sync.sv
module dcnt_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic lvl
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{IDLE}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], raw};
        end
    end

    assign lvl = chain_q[STAGES-1];

endmodule

// File: rtl/dcnt_decade.sv
module dcnt_decade
    import dcnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output bcd_t digit,
    output logic carry
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            digit <= BCD_ZERO;
        end else if (inc) begin
            digit <= bcd_next(digit);
        end
    end

    assign carry = inc && bcd_last(digit);

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        digit <= BCD_TOP);                                            // R2
    AST_DIGIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> digit == BCD_ZERO);                                   // R4
    AST_DIGIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && digit != BCD_TOP) |=> digit == $past(digit) + 4'd1); // R1
    AST_DIGIT_ROLL: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && digit == BCD_TOP) |=> digit == BCD_ZERO);     // R2
    AST_DIGIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(digit));                           // R1

endmodule

// File: rtl/dcnt_hold.sv
module dcnt_hold #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));                                        // R5
    AST_HOLD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(d));                                      // R5

endmodule

// File: rtl/dcnt_top.sv
module dcnt_top
    import dcnt_pkg::*;
#(
    parameter int NUM_DECADES = 8,
    parameter int TAP_COUNT   = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cnt_in,
    input  logic                         clr_n,
    input  logic                         ld_n,
    input  logic                         ovf_in,
    output logic [NUM_DECADES*DIGIT_W-1:0] disp_bcd,
    output logic                         ovf_out,
    output logic [TAP_COUNT-1:0]         tap_msb
);
    localparam int TAP_BASE = NUM_DECADES - TAP_COUNT;
    localparam int N_IN     = 4;

    // input synchronization: {ovf_in, ld_n, clr_n, cnt_in}
    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] lvl_in;
    assign raw_in = {ovf_in, ld_n, clr_n, cnt_in};

    for (genvar s = 0; s < N_IN; s++) begin : g_sync
        dcnt_sync #(.STAGES(SYNC_LEN), .IDLE(1'b1)) u_sync (
            .clk (clk),
            .rst (rst),
            .raw (raw_in[s]),
            .lvl (lvl_in[s])
        );
    end

    // falling-edge detection on count and overflow inputs
    logic cnt_dly, ovf_dly;
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_dly <= 1'b1;
            ovf_dly <= 1'b1;
        end else begin
            cnt_dly <= lvl_in[0];
            ovf_dly <= lvl_in[3];
        end
    end

    ctl_t ctl;
    always_comb begin
        ctl.clr      = !lvl_in[1];
        ctl.load     = !lvl_in[2];
        ctl.cnt_fall = cnt_dly && !lvl_in[0] && lvl_in[1];
        ctl.ovf_fall = ovf_dly && !lvl_in[3];
    end

    // cascaded decades
    bcd_t                 live [NUM_DECADES];
    bcd_t                 held [NUM_DECADES];
    logic [NUM_DECADES:0] chain;
    assign chain[0] = ctl.cnt_fall;

    for (genvar i = 0; i < NUM_DECADES; i++) begin : g_dec
        dcnt_decade u_dec (
            .clk   (clk),
            .rst   (rst),
            .clr   (ctl.clr),
            .inc   (chain[i]),
            .digit (live[i]),
            .carry (chain[i+1])
        );
        dcnt_hold #(.WIDTH(DIGIT_W)) u_hold (
            .clk  (clk),
            .rst  (rst),
            .load (ctl.load),
            .d    (live[i]),
            .q    (held[i])
        );
        assign disp_bcd[i*DIGIT_W +: DIGIT_W] = held[i];
    end

    for (genvar k = 0; k < TAP_COUNT; k++) begin : g_tap
        assign tap_msb[k] = live[TAP_BASE+k][DIGIT_W-1];
    end

    // sticky overflow flag and its held copy
    logic ovf_ff;
    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            ovf_ff <= 1'b0;
        end else if (ctl.ovf_fall) begin
            ovf_ff <= 1'b1;
        end
    end

    dcnt_hold #(.WIDTH(1)) u_ovf_hold (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.load),
        .d    (ovf_ff),
        .q    (ovf_out)
    );

    logic all_zero;
    always_comb begin
        all_zero = 1'b1;
        for (int j = 0; j < NUM_DECADES; j++) begin
            if (live[j] != BCD_ZERO) all_zero = 1'b0;
        end
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        chain[NUM_DECADES] |=> all_zero);                             // R3
    AST_CNT_PULSE: assert property (@(posedge clk) disable iff (rst)
        ctl.cnt_fall |=> !ctl.cnt_fall);                              // R1
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> !ovf_ff);                                         // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_ff && !ctl.clr) |=> ovf_ff);                             // R7
    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (ctl.ovf_fall && !ctl.clr) |=> ovf_ff);                       // R7
    AST_OVF_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl.load |=> $stable(ovf_out));                              // R6
    AST_CLR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |-> !chain[0]);                                       // R4

endmodule

// File: tb/dcnt_top_bench.sv
module dcnt_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SMALL_N    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_in = 1'b1, clr_n = 1'b1, ld_n = 1'b1, ovf_in = 1'b1;

    logic [31:0]          disp_main;
    logic                 ovf_main;
    logic [2:0]           tap_main;
    logic [SMALL_N*4-1:0] disp_small;
    logic                 ovf_small;
    logic [2:0]           tap_small;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcnt_top u_dcnt_top (
        .clk(clk), .rst(rst), .cnt_in(cnt_in), .clr_n(clr_n), .ld_n(ld_n),
        .ovf_in(ovf_in), .disp_bcd(disp_main), .ovf_out(ovf_main), .tap_msb(tap_main)
    );

    // short copy: top tap looped to its own overflow input
    dcnt_top #(.NUM_DECADES(SMALL_N), .TAP_COUNT(3)) u_dcnt_top_small (
        .clk(clk), .rst(rst), .cnt_in(cnt_in), .clr_n(clr_n), .ld_n(ld_n),
        .ovf_in(tap_small[2]), .disp_bcd(disp_small), .ovf_out(ovf_small), .tap_msb(tap_small)
    );

    int total = 0;
    int bad   = 0;
    int main_ref  = 0;
    int small_ref = 0;
    bit finished  = 1'b0;

    function automatic logic [31:0] to_bcd(input int v);
        logic [31:0] r = '0;
        int x = v;
        for (int i = 0; i < 8; i++) begin
            r[i*4 +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_count(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_in = 1'b0; settle(3);
            cnt_in = 1'b1; settle(3);
            if (clr_n) begin
                main_ref  = (main_ref + 1) % 100000000;
                small_ref = (small_ref + 1) % 1000;
            end
        end
    endtask

    task automatic do_load();
        ld_n = 1'b0; settle(5);
        ld_n = 1'b1; settle(5);
    endtask

    task automatic do_clear();
        clr_n = 1'b0; settle(4);
        pulse_count(2);      // ignored while clear is held
        clr_n = 1'b1; settle(4);
        main_ref = 0; small_ref = 0;
    endtask

    task automatic t_reset_state();
        settle(2);
        chk("R9 display after reset", disp_main, 32'h0);
        chk("R9 overflow after reset", {31'b0, ovf_main}, 32'h0);
    endtask

    task automatic t_basic_count();
        pulse_count(7);
        chk("R5 held before load", disp_main, 32'h0);
        do_load();
        chk("R1 seven counts", disp_main, to_bcd(main_ref));
        pulse_count(5);
        chk("R5 hold while load high", disp_main, to_bcd(7));
        do_load();
        chk("R1 twelve counts", disp_main, to_bcd(main_ref));
    endtask

    task automatic t_carry();
        pulse_count(88);
        do_load();
        chk("R2 carry to hundreds", disp_main, 32'h0000_0100);
        pulse_count(19);
        do_load();
        chk("R2 mixed digits", disp_main, to_bcd(main_ref));
    endtask

    task automatic t_clear();
        do_clear();
        do_load();
        chk("R4 clear ignores counts", disp_main, 32'h0);
    endtask

    task automatic t_overflow_main();
        ovf_in = 1'b0; settle(4);
        ovf_in = 1'b1; settle(4);
        chk("R6 overflow not shown before load", {31'b0, ovf_main}, 32'h0);
        do_load();
        chk("R7 overflow set by falling edge", {31'b0, ovf_main}, 32'h1);
        settle(6);
        do_load();
        chk("R7 overflow sticky", {31'b0, ovf_main}, 32'h1);
        do_clear();
        chk("R6 held overflow kept until load", {31'b0, ovf_main}, 32'h1);
        do_load();
        chk("R4 clear resets overflow", {31'b0, ovf_main}, 32'h0);
    endtask

    task automatic t_wrap_small();
        do_clear();
        pulse_count(800);
        chk("R8 live tap of hundreds digit", {29'b0, tap_small}, 32'h4);
        chk("R8 main taps low", {29'b0, tap_main}, 32'h0);
        pulse_count(199);
        do_load();
        chk("R2 small at top value", {20'b0, disp_small}, 32'h999);
        chk("R7 small no overflow yet", {31'b0, ovf_small}, 32'h0);
        pulse_count(1);
        do_load();
        chk("R3 small wraps to zero", {20'b0, disp_small}, 32'h0);
        chk("R7 small overflow from looped tap", {31'b0, ovf_small}, 32'h1);
        chk("R2 main at one thousand", disp_main, to_bcd(main_ref));
    endtask

    initial begin
        settle(4);
        rst = 1'b0;
        settle(2);
        t_reset_state();
        t_basic_count();
        t_carry();
        t_clear();
        t_overflow_main();
        t_wrap_small();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule